// File: doc/BRIEF.md
# Self-correcting three-phase ring divider

This block turns a timing strobe into three square waves. It divides the strobe rate by six, so a 2.4 kHz strobe gives 400 Hz on every output. The three outputs are spaced a third of a period apart. The strobe is a one-clock enable on the system clock. The counter behind the outputs is a three-stage twisted ring. The phases are tapped from that ring so that, in normal running, the three outputs are never all high and never all low together.

The six-state cycle is not the only closed loop a three-stage twisted ring can fall into. Two other states, left over after a glitch or a bad load, alternate with each other forever. In one of them all three phases are high; in the other all three are low. A watch gate sees either pattern and, on the next strobe, clears a single stage instead of advancing. That drops the ring straight into the legal cycle, and a one-clock correction pulse marks the event. The value loaded at reset is a parameter. The default is the legal start state; the other two values exist to recreate the lock-up states.

Top module: `tri_phase_ring`

## Requirements
- R1: A synchronous active-low reset loads the default start state. In that state the phases (a,b,c) are (0,0,1) and the correction pulse is 0.
- R2: On a clock with the strobe low, the three phases and the correction pulse do not change from their reset or post-strobe values; the pulse reads 0.
- R3: From reset, each strobe moves (a,b,c) along the repeating order 001, 101, 100, 110, 010, 011, and then back to 001.
- R4: Each phase is high for three of every six strobes. After reset, a rises on strobe 1, b on strobe 3 and c on strobe 5.
- R5: If the phases are all high, the next strobe loads (0,1,1) by clearing the first ring stage, and running continues from there.
- R6: If the phases are all low, the next strobe loads (0,0,1) by clearing the second ring stage, and running continues from there.
- R7: The correction pulse is high for exactly one clock, right after a strobe that corrected an illegal state, and low at all other times.
- R8: Reset takes priority over a strobe in the same clock.
- R9: After any strobe outside reset, the phases are neither all high nor all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Timing strobe, one clock wide; advances the ring |
| ph_a | output | 1 | First phase |
| ph_b | output | 1 | Second phase, 120 degrees after ph_a |
| ph_c | output | 1 | Third phase, 120 degrees after ph_b |
| fix | output | 1 | One-clock pulse when an illegal state was corrected |

## Verification
The bench starts extra copies of the block with reset values that recreate both lock-up states. A gate that spotted only the all-high pattern would leave the all-low copy flipping between its two illegal states, with the correction pulse never firing. A gate that cleared the wrong stage would land on a state whose phases are neither (0,1,1) nor (0,0,1). Random strobe gaps and random mid-run resets are aimed at the timing. An off-by-one in the tap order would put the b and c rises on the wrong strobes. A ring that ran on every clock would move during gaps with no strobe. A strobe that beat reset in the same clock would leave the wrong start pattern.

// File: rtl/tpr_pkg.sv
// Package: shared types and constants for the three-phase ring divider.
// Assumes a three-stage twisted ring; the tap positions below depend on it.
package tpr_pkg;

    localparam int RING_LEN = 3;
    localparam int TAP_A    = 0;             // first phase follows stage 0
    localparam int TAP_B    = RING_LEN - 1;  // second phase follows last stage
    localparam int TAP_C    = 1;             // third phase is inverted stage 1
    localparam int CLR_HI   = 0;             // stage cleared on all-high
    localparam int CLR_LO   = 1;             // stage cleared on all-low

    typedef logic [RING_LEN-1:0] ring_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } phase_t;

    typedef enum logic [1:0] {
        SEQ_OK     = 2'd0,
        SEQ_ALL_HI = 2'd1,
        SEQ_ALL_LO = 2'd2
    } seq_e;

endpackage

// File: rtl/tpr_taps.sv
// Module: tpr_taps
// Maps the ring register onto three phases spaced 120 degrees apart.
// Assumes the twisted-ring stage order defined in tpr_pkg.
module tpr_taps
    import tpr_pkg::*;
(
    input  ring_t  q,
    output phase_t ph
);

    // Purpose: pick the taps, inverting stage 1 for the third phase.
    always_comb begin
        ph.a = q[TAP_A];
        ph.b = q[TAP_B];
        ph.c = ~q[TAP_C];
    end

endmodule

// File: rtl/tpr_guard.sv
// Module: tpr_guard
// Sequence watch gate: classifies the phase pattern as legal, all high or
// all low. Assumes the phases come straight from tpr_taps.
module tpr_guard
    import tpr_pkg::*;
(
    input  phase_t ph,
    output seq_e   kind
);

    // Purpose: flag the two patterns that only the lock-up loop produces.
    always_comb begin
        if (ph.a && ph.b && ph.c)
            kind = SEQ_ALL_HI;
        else if (!ph.a && !ph.b && !ph.c)
            kind = SEQ_ALL_LO;
        else
            kind = SEQ_OK;
    end

endmodule

// File: rtl/tpr_core.sv
// Module: tpr_core
// Twisted-ring register. On each strobe it shifts by one stage, or it clears
// a single stage when the guard reports an illegal pattern. Also raises a
// one-clock correction pulse. Assumes step lasts one clock.
module tpr_core
    import tpr_pkg::*;
#(
    parameter ring_t INIT_STATE = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  seq_e  kind,
    output ring_t q,
    output logic  fix
);

    ring_t shifted;
    ring_t nxt;

    // Purpose: the feedback stage takes the inverted last stage.
    always_comb shifted[0] = ~q[RING_LEN-1];

    // Purpose: every other stage takes the stage before it.
    for (genvar i = 1; i < RING_LEN; i++) begin : g_shift
        always_comb shifted[i] = q[i-1];
    end

    // Purpose: choose between a normal advance and a single-stage clear.
    always_comb begin
        case (kind)
            SEQ_ALL_HI: nxt = q & ~(ring_t'(1) << CLR_HI);
            SEQ_ALL_LO: nxt = q & ~(ring_t'(1) << CLR_LO);
            default:    nxt = shifted;
        endcase
    end

    // Purpose: ring register, loaded on reset and updated on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= INIT_STATE;
        else if (step)
            q <= nxt;
    end

    // Purpose: one-clock pulse after a strobe that corrected the ring.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fix <= 1'b0;
        else
            fix <= step && (kind != SEQ_OK);
    end

endmodule

// File: rtl/tri_phase_ring.sv
// Module: tri_phase_ring
// Top level: a divide-by-six three-phase generator with self-correction.
// The ring is in tpr_core, phase taps in tpr_taps, and the watch gate in
// tpr_guard. INIT_STATE is the ring value loaded at reset; its default
// is the legal start.
module tri_phase_ring #(
    parameter logic [2:0] INIT_STATE = 3'b000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic ph_a,
    output logic ph_b,
    output logic ph_c,
    output logic fix
);
    import tpr_pkg::*;

    ring_t  ring_q;
    phase_t phases;
    seq_e   seq_kind;

    tpr_core #(.INIT_STATE(ring_t'(INIT_STATE))) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .kind  (seq_kind),
        .q     (ring_q),
        .fix   (fix)
    );

    tpr_taps u_taps (
        .q  (ring_q),
        .ph (phases)
    );

    tpr_guard u_guard (
        .ph   (phases),
        .kind (seq_kind)
    );

    // Purpose: drive the phase pins from the tap struct.
    always_comb begin
        ph_a = phases.a;
        ph_b = phases.b;
        ph_c = phases.c;
    end

endmodule

// File: rtl/tpr_checker.sv
// Module: tpr_checker
// Assertions for tri_phase_ring, attached through a bind statement.
// Assumes a synchronous active-low reset that is low from time zero.
module tpr_checker (
    input logic clk,
    input logic rst_n,
    input logic step,
    input logic ph_a,
    input logic ph_b,
    input logic ph_c,
    input logic fix
);

    logic legal;
    always_comb legal = !(ph_a && ph_b && ph_c) && (ph_a || ph_b || ph_c);

    // R2: with no strobe the phases hold
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable({ph_a, ph_b, ph_c}));

    // R3: a legal pattern rotates a<=~b, b<=~c, c<=~a on a strobe
    assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && legal) |=> (ph_a == !$past(ph_b)) && (ph_b == !$past(ph_c))
                            && (ph_c == !$past(ph_a)));

    // R5: all high is replaced by (0,1,1)
    assert_fix_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ph_a && ph_b && ph_c) |=> (!ph_a && ph_b && ph_c));

    // R6: all low is replaced by (0,0,1)
    assert_fix_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ph_a && !ph_b && !ph_c) |=> (!ph_a && !ph_b && ph_c));

    // R7: correction pulse lasts one clock and follows a strobe
    assert_pulse_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fix |=> !fix);
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fix |-> $past(step));

    // R9: a strobe always leaves a legal pattern
    assert_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> legal);

endmodule

bind tri_phase_ring tpr_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .ph_a  (ph_a),
    .ph_b  (ph_b),
    .ph_c  (ph_c),
    .fix   (fix)
);

// File: tb/sim_tri_phase_ring.sv
// Bench for tri_phase_ring: u0 starts legal, u1 and u2 reset into the
// all-high and all-low lock-up states. Random strobes and resets are mixed
// with directed cases; expected values come from bench functions.
module sim_tri_phase_ring;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0;
    logic [2:0] ph [3];
    logic       fx [3];

    int total = 0;
    int bad = 0;
    int k [3];
    logic fe [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_phase_ring u0 (.clk(clk), .rst_n(rst_n), .step(step),
        .ph_a(ph[0][2]), .ph_b(ph[0][1]), .ph_c(ph[0][0]), .fix(fx[0]));
    tri_phase_ring #(.INIT_STATE(3'b101)) u1 (.clk(clk), .rst_n(rst_n), .step(step),
        .ph_a(ph[1][2]), .ph_b(ph[1][1]), .ph_c(ph[1][0]), .fix(fx[1]));
    tri_phase_ring #(.INIT_STATE(3'b010)) u2 (.clk(clk), .rst_n(rst_n), .step(step),
        .ph_a(ph[2][2]), .ph_b(ph[2][1]), .ph_c(ph[2][0]), .fix(fx[2]));

    // Expected {a,b,c} for sequence index kk; -1 means the illegal reset state.
    function automatic logic [2:0] exp_ph(int kk, int inst);
        if (kk < 0) return (inst == 1) ? 3'b111 : 3'b000;
        case (kk)
            0: return 3'b001;
            1: return 3'b101;
            2: return 3'b100;
            3: return 3'b110;
            4: return 3'b010;
            default: return 3'b011;
        endcase
    endfunction

    task automatic check(string tag, int inst, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s inst=%0d actual=%b expected=%b", tag, inst, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model, sample 1 time unit after posedge.
    task automatic cycle(logic r, logic s, string force_tag = "");
        string tag;
        @(negedge clk);
        rst_n = r;
        step = s;
        @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) begin
            fe[i] = 1'b0;
            if (!r) begin
                k[i] = (i == 0) ? 0 : -1;
                tag = "R1";
            end else if (s) begin
                if (k[i] < 0) begin
                    fe[i] = 1'b1;
                    k[i] = (i == 1) ? 5 : 0;
                    tag = (i == 1) ? "R5" : "R6";
                end else begin
                    k[i] = (k[i] + 1) % 6;
                    tag = "R3";
                end
            end else begin
                tag = "R2";
            end
            if (force_tag != "") tag = force_tag;
            check(tag, i, {ph[i], fx[i]}, {exp_ph(k[i], i), fe[i]});
            if (fe[i] || (r && !s)) check("R7", i, {3'b000, fx[i]}, {3'b000, fe[i]});
            if (r && s) check("R9", i, {3'b000, (ph[i] == 3'b111 || ph[i] == 3'b000)}, 4'b0000);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rise [3];
        int highs [3];
        logic [2:0] prev;
        void'($urandom(32'd2024));
        for (int i = 0; i < 3; i++) k[i] = 0;

        // R1: reset state of every instance
        cycle(1'b0, 1'b0, "R1");
        cycle(1'b0, 1'b0, "R1");
        // R2: no strobe, nothing moves
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b0);
        // R5 / R6: first strobe corrects u1 and u2
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        // R8: reset wins over a simultaneous strobe
        cycle(1'b0, 1'b1, "R8");

        // R4: rise order and duty over six strobes on u0
        for (int i = 0; i < 3; i++) begin rise[i] = -1; highs[i] = 0; end
        prev = ph[0];
        for (int n = 1; n <= 6; n++) begin
            cycle(1'b1, 1'b1);
            for (int b = 0; b < 3; b++) begin
                if (ph[0][2-b] && !prev[2-b] && rise[b] < 0) rise[b] = n;
                if (ph[0][2-b]) highs[b]++;
            end
            prev = ph[0];
        end
        check("R4", 0, 4'(rise[0]), 4'd1);
        check("R4", 0, 4'(rise[1]), 4'd3);
        check("R4", 0, 4'(rise[2]), 4'd5);
        for (int b = 0; b < 3; b++) check("R4", 0, 4'(highs[b]), 4'd3);

        // Random strobes and occasional resets
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom % 60) != 0, ($urandom % 3) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule